// File: doc/BRIEF.md
# Stream DMA channel

This block is one DMA channel between a word-addressed memory and a 32-bit streaming port. Software places a chain of buffer descriptors in memory. Each descriptor is a 16-word record, and each is placed on a 128-byte boundary. Software then points the channel at the first descriptor, sets it running and writes the tail pointer. The channel reads each descriptor and moves the buffer it names, then writes a completion record back into the descriptor and follows the next pointer. It stops once the descriptor whose address equals the tail has finished.

A parameter fixes the direction when the block is instantiated. In the transmit variant, buffer words are read from memory and sent out on the stream. In the receive variant, stream words are written into the buffer until the sender marks the last word or the buffer is full, and the received byte count is stored in the descriptor. A small register file holds run/stop, a self-clearing soft reset, interrupt enables, the halted and idle flags, write-one-to-clear event flags, and the current and tail pointers.

Top module: `sdma_chan`

## Requirements
- R1: After reset, control reads 0, status reads 0x3 (bit 0 halted, bit 1 idle), the current and tail pointers read 0, and irq, mem_req, m_valid and s_ready are low.
- R2: Registers sit at byte offsets 0x00 control, 0x04 status, 0x08 current pointer and 0x10 tail pointer. Control bit 0 is run, bit 2 is soft reset and bits 14..12 are interrupt enables. Status bits 14..12 are the event flags.
- R3: Writing control with bit 0 set clears the halted flag. With bit 0 clear, an idle channel sets halted.
- R4: A write to the current pointer takes effect only while the channel is halted.
- R5: A tail write while the channel is running and not halted starts work at the current pointer. The channel follows word 0 (next pointer) from one descriptor to the next and stops after the descriptor equal to the tail completes. It then stays running and not halted, with the idle flag set.
- R6: Transmit reads word 2 (buffer address) and word 6 (control: byte length in the low bits, bit 26 last packet, bit 27 first packet). It sends ceil(length/4) buffer words in ascending address order. m_last is raised only on the final word, and only when bit 26 is set.
- R7: Receive writes stream words to ascending buffer addresses. It stops after a word with s_last or when ceil(length/4) words are stored, whichever comes first. The next descriptor takes any remaining words. The byte count (4 per word) goes into the low 16 bits of word 12.
- R8: Each completed descriptor gets status word 7 = bit 31 set plus the byte count (the programmed length for transmit, the received bytes for receive).
- R9: Each completion sets status bit 12. Writing ones to status bits 14..12 clears them, and writing zeros leaves them unchanged.
- R10: irq is high exactly when some status bit 12..14 and its control enable are both set.
- R11: Writing control bit 2 abandons any transfer and returns all registers to their reset values. Control bit 2 then reads 1 for RST_CYC cycles, and during that time the memory and the stream stay quiet.
- R12: A descriptor or buffer address with nonzero low 7 bits sets status bit 14 and halts the channel before any data moves.
- R13: A memory request keeps its address and direction until acknowledged. m_valid and its data stay steady until m_ready.
- R14: A tail write while the channel is halted starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; completes the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| m_valid | output | 1 | Outgoing stream word valid |
| m_data | output | 32 | Outgoing stream word |
| m_last | output | 1 | Final word of a packet |
| m_ready | input | 1 | Outgoing stream accept |
| s_valid | input | 1 | Incoming stream word valid |
| s_data | input | 32 | Incoming stream word |
| s_last | input | 1 | Final incoming word |
| s_ready | output | 1 | Incoming stream accept |

## Verification
Some properties are checked on every cycle by the assertions. Memory requests and outgoing stream words must hold steady until accepted. A halted channel and a channel in soft reset must issue no memory or stream traffic. A current-pointer write made while the channel runs must leave the pointer unchanged. A write of one to status bit 12 must clear that flag. Other behaviour only the directed scenarios can show: walking a two-descriptor chain under memory and stream stalls, the last-word marking, the written-back completion and length words, the receive split when a buffer fills, recovery from soft reset, and the halt on a misaligned pointer.

// File: rtl/sdma_chan.sv
`timescale 1ns/1ps
module sdma_chan #(
  parameter int AW      = 12,
  parameter int LEN_W   = 16,
  parameter int RST_CYC = 4,
  parameter bit RX_MODE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          m_valid,
  output logic [31:0]   m_data,
  output logic          m_last,
  input  logic          m_ready,
  input  logic          s_valid,
  input  logic [31:0]   s_data,
  input  logic          s_last,
  output logic          s_ready
);
  localparam int RCW = $clog2(RST_CYC + 1);
  localparam logic [4:0] A_CTL = 5'h00, A_STS = 5'h04, A_CUR = 5'h08, A_TAIL = 5'h10;

  typedef enum logic [3:0] {
    S_IDLE, S_NEXT, S_BUF, S_CTL, S_XRD, S_XOUT, S_XIN, S_XWR, S_WLEN, S_WSTS, S_DONE
  } st_t;

  st_t              st;
  logic             run, halted, lastf, rxend;
  logic [2:0]       ien, flags, fl_set, fl_clr;
  logic [AW-1:0]    cur, tail, nxt, bufa, off;
  logic [LEN_W-1:0] len, cnt, nbeats;
  logic [LEN_W+1:0] rx_bytes;
  logic [31:0]      dbuf;
  logic [RCW-1:0]   rcnt;
  logic             srst_busy, soft_wr, wr_ctl, wr_sts, wr_cur, wr_tail;
  logic             start, err_now, fin, adv, in_data;
  logic             unused_bits;

  assign srst_busy = rcnt != '0;
  assign wr_ctl  = reg_we && !srst_busy && reg_addr == A_CTL;
  assign wr_sts  = reg_we && !srst_busy && reg_addr == A_STS;
  assign wr_cur  = reg_we && !srst_busy && reg_addr == A_CUR;
  assign wr_tail = reg_we && !srst_busy && reg_addr == A_TAIL;
  assign soft_wr = wr_ctl && reg_wdata[2];

  assign nbeats   = LEN_W'(({1'b0, len} + (LEN_W+1)'(3)) >> 2);
  assign rx_bytes = {cnt, 2'b00};

  assign start   = st == S_IDLE && wr_tail && run && !halted;
  assign fin     = st == S_DONE && cur == tail;
  assign adv     = st == S_DONE && cur != tail && run;
  assign err_now = (start && cur[6:0] != '0) ||
                   (st == S_BUF && mem_ack && mem_rdata[6:0] != '0) ||
                   (adv && nxt[6:0] != '0);
  assign fl_set  = {err_now, 1'b0, st == S_DONE};
  assign fl_clr  = wr_sts ? reg_wdata[14:12] : 3'b000;

  always_comb begin
    case (st)
      S_NEXT, S_BUF, S_CTL, S_XWR, S_WLEN, S_WSTS: mem_req = 1'b1;
      S_XRD:   mem_req = cnt != nbeats;
      default: mem_req = 1'b0;
    endcase
  end

  always_comb begin
    case (st)
      S_BUF:   off = AW'(8);
      S_CTL:   off = AW'(24);
      S_WSTS:  off = AW'(28);
      S_WLEN:  off = AW'(48);
      default: off = '0;
    endcase
  end

  assign in_data   = st == S_XRD || st == S_XWR;
  assign mem_we    = st == S_XWR || st == S_WLEN || st == S_WSTS;
  assign mem_addr  = in_data ? bufa + AW'({cnt, 2'b00}) : cur + off;
  assign mem_wdata = st == S_XWR  ? dbuf :
                     st == S_WLEN ? {16'h0000, 16'(rx_bytes)} :
                     {1'b1, 5'b00000, RX_MODE ? 26'(rx_bytes) : 26'(len)};

  assign m_valid = st == S_XOUT;
  assign m_data  = dbuf;
  assign m_last  = m_valid && lastf && cnt == nbeats - 1'b1;
  assign s_ready = st == S_XIN && cnt != nbeats && !rxend;
  assign irq     = |(flags & ien);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTL:  begin reg_rdata[0] = run; reg_rdata[2] = srst_busy; reg_rdata[14:12] = ien; end
      A_STS:  begin reg_rdata[0] = halted; reg_rdata[1] = st == S_IDLE; reg_rdata[14:12] = flags; end
      A_CUR:  reg_rdata[AW-1:0] = cur;
      A_TAIL: reg_rdata[AW-1:0] = tail;
      default: reg_rdata = '0;
    endcase
  end

  assign unused_bits = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; run <= 1'b0; halted <= 1'b1; ien <= '0; flags <= '0;
      cur <= '0; tail <= '0; nxt <= '0; bufa <= '0; len <= '0; cnt <= '0;
      lastf <= 1'b0; rxend <= 1'b0; dbuf <= '0; rcnt <= '0;
    end else if (soft_wr) begin
      st <= S_IDLE; run <= 1'b0; halted <= 1'b1; ien <= '0; flags <= '0;
      cur <= '0; tail <= '0; nxt <= '0; bufa <= '0; len <= '0; cnt <= '0;
      lastf <= 1'b0; rxend <= 1'b0; dbuf <= '0; rcnt <= RCW'(RST_CYC);
    end else begin
      if (srst_busy) rcnt <= rcnt - 1'b1;
      flags <= (flags & ~fl_clr) | fl_set;
      case (st)
        S_IDLE: begin
          if (start) st <= S_NEXT;
          else if (!run) halted <= 1'b1;
        end
        S_NEXT: if (mem_ack) begin nxt <= mem_rdata[AW-1:0]; st <= S_BUF; end
        S_BUF:  if (mem_ack) begin bufa <= mem_rdata[AW-1:0]; st <= S_CTL; end
        S_CTL:  if (mem_ack) begin
          len   <= mem_rdata[LEN_W-1:0];
          lastf <= mem_rdata[26];
          cnt   <= '0;
          rxend <= 1'b0;
          st    <= RX_MODE ? S_XIN : S_XRD;
        end
        S_XRD: begin
          if (cnt == nbeats) st <= S_WSTS;
          else if (mem_ack) begin dbuf <= mem_rdata; st <= S_XOUT; end
        end
        S_XOUT: if (m_ready) begin cnt <= cnt + 1'b1; st <= S_XRD; end
        S_XIN: begin
          if (cnt == nbeats || rxend) st <= S_WLEN;
          else if (s_valid) begin dbuf <= s_data; rxend <= s_last; st <= S_XWR; end
        end
        S_XWR:  if (mem_ack) begin cnt <= cnt + 1'b1; st <= S_XIN; end
        S_WLEN: if (mem_ack) st <= S_WSTS;
        S_WSTS: if (mem_ack) st <= S_DONE;
        S_DONE: begin
          if (fin) st <= S_IDLE;
          else if (adv) begin cur <= nxt; st <= S_NEXT; end
          else begin cur <= nxt; halted <= 1'b1; st <= S_IDLE; end
        end
        default: st <= S_IDLE;
      endcase
      if (err_now) begin halted <= 1'b1; st <= S_IDLE; end
      if (wr_ctl) begin
        run <= reg_wdata[0];
        ien <= reg_wdata[14:12];
        if (reg_wdata[0] && !err_now) halted <= 1'b0;
      end
      if (wr_cur && halted) cur <= reg_wdata[AW-1:0];
      if (wr_tail) tail <= reg_wdata[AW-1:0];
    end
  end

  // R13
  memhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !soft_wr |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R13
  strhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready && !soft_wr |=> m_valid && $stable(m_data) && $stable(m_last));

  // R12
  haltquiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req && !m_valid && !s_ready);

  // R11
  srstquiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> !mem_req && !m_valid && !s_ready && !irq);

  // R4
  curlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cur && !halted && st == S_IDLE |=> cur == $past(cur));

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sts && reg_wdata[12] && st != S_DONE |=> !reg_rdata[12] || reg_addr != A_STS);
endmodule

// File: tb/sdma_chan_bench.sv
`timescale 1ns/1ps
module sdma_chan_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, smode = 0, rmode = 0;
  bit finished = 1'b0;

  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we_t = 1'b0, we_r = 1'b0;

  logic [31:0] rdata_t, rdata_r, mrdata_t, mrdata_r, mwdata_t, mwdata_r, md_t, md_r;
  logic [11:0] maddr_t, maddr_r;
  logic        irq_t, irq_r, mreq_t, mreq_r, mwe_t, mwe_r, mack_t, mack_r;
  logic        mv_t, ml_t, mv_r, ml_r, sr_t, sr_r, mrdy_t, gate;

  logic [31:0] memt [0:1023];
  logic [31:0] memr [0:1023];

  logic [31:0] cap_d [0:63];
  logic        cap_l [0:63];
  int          ncap = 0;

  logic [31:0] src_d [0:15];
  int          src_i = 0, src_n = 0;
  logic        src_lastf = 1'b0, src_load = 1'b0;
  logic        sv_r, sl_r;
  logic [31:0] sd_r;

  always @(posedge clk) cyc <= cyc + 1;
  assign gate   = (smode == 0) || (cyc % 3 != 1);
  assign mrdy_t = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 2 == 0) : 1'b0;

  assign mack_t   = mreq_t && gate;
  assign mack_r   = mreq_r && gate;
  assign mrdata_t = memt[maddr_t[11:2]];
  assign mrdata_r = memr[maddr_r[11:2]];

  always @(posedge clk) begin
    if (mreq_t && mack_t && mwe_t) memt[maddr_t[11:2]] <= mwdata_t;
    if (mreq_r && mack_r && mwe_r) memr[maddr_r[11:2]] <= mwdata_r;
    if (mv_t && mrdy_t) begin
      cap_d[ncap] <= md_t;
      cap_l[ncap] <= ml_t;
      ncap <= ncap + 1;
    end
    if (src_load) src_i <= 0;
    else if (sv_r && sr_r) src_i <= src_i + 1;
  end

  assign sv_r = src_i < src_n;
  assign sd_r = src_d[src_i % 16];
  assign sl_r = src_lastf && (src_i == src_n - 1);

  sdma_chan #(.RX_MODE(1'b0)) u_sdma_chan (
    .clk(clk), .rst_n(rst_n), .reg_we(we_t), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata_t), .irq(irq_t), .mem_req(mreq_t), .mem_we(mwe_t),
    .mem_addr(maddr_t), .mem_wdata(mwdata_t), .mem_ack(mack_t), .mem_rdata(mrdata_t),
    .m_valid(mv_t), .m_data(md_t), .m_last(ml_t), .m_ready(mrdy_t),
    .s_valid(1'b0), .s_data(32'h0), .s_last(1'b0), .s_ready(sr_t));

  sdma_chan #(.RX_MODE(1'b1)) u_sdma_chan_rx (
    .clk(clk), .rst_n(rst_n), .reg_we(we_r), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata_r), .irq(irq_r), .mem_req(mreq_r), .mem_we(mwe_r),
    .mem_addr(maddr_r), .mem_wdata(mwdata_r), .mem_ack(mack_r), .mem_rdata(mrdata_r),
    .m_valid(mv_r), .m_data(), .m_last(ml_r), .m_ready(1'b0),
    .s_valid(sv_r), .s_data(sd_r), .s_last(sl_r), .s_ready(sr_r));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit rx, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we_t = !rx; we_r = rx;
    @(negedge clk);
    we_t = 1'b0; we_r = 1'b0;
  endtask

  task automatic rd(input bit rx, input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rx ? rdata_r : rdata_t;
  endtask

  task automatic wait_idle(input bit rx);
    logic [31:0] s;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      rd(rx, 5'h04, s);
      if (s[1]) break;
    end
  endtask

  task automatic load_src(input int n, input logic lastf, input logic [31:0] base);
    for (int i = 0; i < n; i++) src_d[i] = base + i;
    @(negedge clk);
    src_load = 1'b1; src_n = n; src_lastf = lastf;
    @(negedge clk);
    src_load = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, 5'h00, v); chk("R1 tx ctrl", v, 32'h0);
    rd(0, 5'h04, v); chk("R1 tx status", v, 32'h3);
    rd(0, 5'h08, v); chk("R1 tx cur", v, 32'h0);
    rd(1, 5'h10, v); chk("R1 rx tail", v, 32'h0);
    rd(1, 5'h04, v); chk("R1 rx status", v, 32'h3);
    chk("R1 outputs", {28'h0, irq_t, mreq_t, mv_t, sr_r}, 32'h0);
  endtask

  task automatic t_tx_chain;
    logic [31:0] v;
    smode = 1; rmode = 1;
    memt[64] = 32'h180; memt[66] = 32'h400; memt[70] = 32'h0800_000A;
    memt[96] = 32'h100; memt[98] = 32'h480; memt[102] = 32'h0400_0008;
    for (int i = 0; i < 4; i++) begin
      memt[256 + i] = 32'hA000_0000 + i;
      memt[288 + i] = 32'hB000_0000 + i;
    end
    wr(0, 5'h08, 32'h100);
    wr(0, 5'h00, 32'h1001);
    rd(0, 5'h04, v); chk("R3 run clears halted", v, 32'h2);
    rd(0, 5'h00, v); chk("R2 ctrl readback", v, 32'h1001);
    wr(0, 5'h10, 32'h180);
    wait_idle(0);
    chk("R6 beat count", ncap, 5);
    chk("R6 word0", cap_d[0], 32'hA000_0000);
    chk("R6 word2", cap_d[2], 32'hA000_0002);
    chk("R5 second desc word", cap_d[3], 32'hB000_0000);
    chk("R6 word4", cap_d[4], 32'hB000_0001);
    chk("R6 last flags", {cap_l[0], cap_l[1], cap_l[2], cap_l[3], cap_l[4]}, 32'h1);
    chk("R8 status word A", memt[71], 32'h8000_000A);
    chk("R8 status word B", memt[103], 32'h8000_0008);
    rd(0, 5'h04, v); chk("R5 R9 status idle running flag", v, 32'h1002);
    chk("R10 irq", irq_t, 1'b1);
    rd(0, 5'h08, v); chk("R5 cur at tail", v, 32'h180);
    smode = 0; rmode = 0;
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(0, 5'h04, 32'h0);
    rd(0, 5'h04, v); chk("R9 zero write keeps flag", v, 32'h1002);
    wr(0, 5'h04, 32'h1000);
    rd(0, 5'h04, v); chk("R9 one write clears flag", v, 32'h2);
    chk("R10 irq low", irq_t, 1'b0);
  endtask

  task automatic t_curlock;
    logic [31:0] v;
    wr(0, 5'h08, 32'h300);
    rd(0, 5'h08, v); chk("R4 cur ignored while running", v, 32'h180);
  endtask

  task automatic t_run_halt;
    logic [31:0] v;
    int n0;
    wr(0, 5'h00, 32'h1000);
    rd(0, 5'h04, v); chk("R3 stop sets halted", v, 32'h3);
    n0 = ncap;
    wr(0, 5'h10, 32'h100);
    repeat (20) @(negedge clk);
    chk("R14 no beats while halted", ncap, n0);
    rd(0, 5'h04, v); chk("R14 status unchanged", v, 32'h3);
    wr(0, 5'h08, 32'h100);
    rd(0, 5'h08, v); chk("R4 cur written while halted", v, 32'h100);
    wr(0, 5'h00, 32'h1001);
    rd(0, 5'h04, v); chk("R3 restart", v, 32'h2);
  endtask

  task automatic t_soft_reset;
    logic [31:0] v;
    int n0;
    rmode = 2;
    memt[160] = 32'h280; memt[162] = 32'h500; memt[166] = 32'd64;
    wr(0, 5'h00, 32'h0);
    wr(0, 5'h08, 32'h280);
    wr(0, 5'h00, 32'h1001);
    n0 = ncap;
    wr(0, 5'h10, 32'h280);
    repeat (8) @(negedge clk);
    chk("R13 stalled valid held", mv_t, 1'b1);
    wr(0, 5'h00, 32'h4);
    rd(0, 5'h00, v); chk("R11 reset bit reads one", v, 32'h4);
    chk("R11 stream dropped", mv_t, 1'b0);
    rd(0, 5'h04, v); chk("R11 status during reset", v, 32'h3);
    repeat (6) @(negedge clk);
    rd(0, 5'h00, v); chk("R11 reset bit clears", v, 32'h0);
    rd(0, 5'h08, v); chk("R11 cur cleared", v, 32'h0);
    rd(0, 5'h10, v); chk("R11 tail cleared", v, 32'h0);
    chk("R11 no beats delivered", ncap, n0);
    rmode = 0;
  endtask

  task automatic t_misalign;
    logic [31:0] v;
    int n0;
    n0 = ncap;
    wr(0, 5'h08, 32'h104);
    wr(0, 5'h00, 32'h4001);
    wr(0, 5'h10, 32'h104);
    repeat (4) @(negedge clk);
    rd(0, 5'h04, v); chk("R12 error halts", v, 32'h4003);
    chk("R12 R10 irq on error", irq_t, 1'b1);
    chk("R12 no data", ncap, n0);
    wr(0, 5'h04, 32'h7000);
    rd(0, 5'h04, v); chk("R9 clear group", v, 32'h3);
  endtask

  task automatic t_rx_single;
    logic [31:0] v;
    smode = 1;
    memr[128] = 32'h200; memr[130] = 32'h600; memr[134] = 32'h0C00_0020;
    wr(1, 5'h08, 32'h200);
    wr(1, 5'h00, 32'h1001);
    load_src(3, 1'b1, 32'hC000_0000);
    wr(1, 5'h10, 32'h200);
    wait_idle(1);
    chk("R7 rx word0", memr[384], 32'hC000_0000);
    chk("R7 rx word2", memr[386], 32'hC000_0002);
    chk("R7 stop at last", memr[387], 32'h0);
    chk("R7 rx length word", memr[140], 32'd12);
    chk("R8 rx status word", memr[135], 32'h8000_000C);
    rd(1, 5'h04, v); chk("R9 rx flag", v, 32'h1002);
    smode = 0;
  endtask

  task automatic t_rx_full;
    memr[160] = 32'h300; memr[162] = 32'h700; memr[166] = 32'd8;
    memr[192] = 32'h300; memr[194] = 32'h780; memr[198] = 32'd16;
    wr(1, 5'h00, 32'h0);
    wr(1, 5'h08, 32'h280);
    wr(1, 5'h00, 32'h1001);
    load_src(5, 1'b1, 32'hD000_0000);
    wr(1, 5'h10, 32'h300);
    wait_idle(1);
    chk("R7 full buffer word1", memr[449], 32'hD000_0001);
    chk("R7 full buffer length", memr[172], 32'd8);
    chk("R8 full buffer status", memr[167], 32'h8000_0008);
    chk("R7 spill to next", memr[480], 32'hD000_0002);
    chk("R7 next last word", memr[482], 32'hD000_0004);
    chk("R7 next untouched", memr[483], 32'h0);
    chk("R7 next length", memr[204], 32'd12);
    chk("R8 next status", memr[199], 32'h8000_000C);
    chk("R7 source drained", sv_r, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin memt[i] = '0; memr[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_chain();
    t_w1c();
    t_curlock();
    t_run_halt();
    t_soft_reset();
    t_misalign();
    t_rx_single();
    t_rx_full();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule